// File: doc/BRIEF.md
# Streaming Pixel Motion Detector

This block takes grayscale pixels in raster order, one per clock under a valid/ready handshake, and decides for each pixel whether it belongs to a moving object on the road. With every pixel it receives four 8-bit samples: the stored background, the frame before, the current frame and the frame after. Alongside these come a road-mask bit, a road-area weight and the pixel's stationary counter. The motion test has two parts. The first is a lateral three-frame difference built from the pixel and from the samples a fixed distance to its left and right in the same stream. The second is a brightness gap between the current frame and the background. Thresholds and the stationary frame count are run-time inputs.

For each pixel the block returns three things. The first is the masked pixel (the current sample when the pixel is moving, zero otherwise). The second is the background to store back. The third is the updated stationary counter. Over the frame it adds up the road-area weights of the moving pixels. The block holds horizontal neighbours in a small internal shift window. After the pixel flagged as the last of a frame, it drains that window by itself. Frame storage and host control sit outside the block.

Top module: `mdet_top`

## Requirements
- R1: While reset is held and right after it, `m_valid` and `area_done` are 0, `area_total` is 0 and `s_ready` is 1.
- R2: Each pixel's difference sample is next minus previous, in signed form. The left and right samples are the difference samples `NB_DIST` positions earlier and later in the stream. When such a position lies outside the centre pixel's row (column below `NB_DIST`, or column plus `NB_DIST` at or beyond `FRAME_W`), the centre difference is used in its place. Columns count from 0 at the pixel flagged `s_sof`.
- R3: The motion value is |left + 2·centre + right|. It is 0 whenever `s_road` is 0, so such a pixel never counts as moving.
- R4: When motion < `cfg_mot_thr` and counter ≥ `cfg_still_n`, `m_bg` is the current pixel and `m_cnt` is 0.
- R5: In every other case `m_bg` is the input background and `m_cnt` is the counter plus one. The counter holds at its all-ones value instead of wrapping.
- R6: `m_pix` equals the current pixel when (current − background), taken as a signed value, is greater than `cfg_bg_thr` and motion is greater than `cfg_mot_thr`. Otherwise `m_pix` is 0.
- R7: `area_total` is the sum of the area weights of the moving pixels of a frame. The pixel flagged `s_sof` restarts the sum. In the cycle after the pixel flagged `s_last` leaves the window, `area_total` takes the frame's sum and `area_done` is 1 for exactly one cycle.
- R8: Every accepted pixel gives exactly one output, in input order. While `m_valid` is 1 and `m_ready` is 0, all output fields hold steady.
- R9: Once a pixel flagged `s_last` is accepted, `s_ready` stays 0 for `NB_DIST`+1 unstalled cycles while the window drains. It then returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_valid | input | 1 | Input pixel valid |
| s_ready | output | 1 | Block can take a pixel |
| s_sof | input | 1 | First pixel of a frame |
| s_last | input | 1 | Last pixel of a frame |
| s_bg | input | 8 | Stored background sample |
| s_prev | input | 8 | Sample from the frame before |
| s_cur | input | 8 | Sample from the current frame |
| s_next | input | 8 | Sample from the frame after |
| s_road | input | 1 | Pixel lies on the road |
| s_area | input | AREA_W | Road-area weight of the pixel |
| s_cnt | input | CNT_W | Stationary counter of the pixel |
| cfg_mot_thr | input | 10 | Motion threshold |
| cfg_bg_thr | input | 8 | Background gap threshold |
| cfg_still_n | input | CNT_W | Frames still before background refresh |
| m_valid | output | 1 | Output pixel valid |
| m_ready | input | 1 | Downstream takes the output |
| m_pix | output | 8 | Masked pixel |
| m_bg | output | 8 | Background to store back |
| m_cnt | output | CNT_W | Stationary counter to store back |
| area_total | output | ACC_W | Moving road area of the last finished frame |
| area_done | output | 1 | One-cycle pulse when `area_total` is updated |

## Verification
The bench aims at the row edges, where a design that borrowed neighbours from the adjacent row would report motion on still pixels near the frame border. It drives counters at the all-ones value, which a wrapping counter would return as zero. It also drives off-road pixels with strong motion, which a design that skipped the mask would pass through and count in the area. Random backpressure tests that outputs stay frozen while stalled and that none is lost or repeated. The frame end tests that the window drains for exactly the expected number of cycles and that the last pixels of a frame are decided before the area total is released.

// File: rtl/mdet_pkg.sv
package mdet_pkg;

  localparam int PIX_W  = 8;
  localparam int DIFF_W = PIX_W + 1;
  localparam int SUM_W  = PIX_W + 4;
  localparam int MOT_W  = PIX_W + 2;

  typedef logic [PIX_W-1:0]         pix_t;
  typedef logic signed [DIFF_W-1:0] diff_t;
  typedef logic [MOT_W-1:0]         mot_t;

  // temporal difference of one pixel: later frame minus earlier frame
  function automatic diff_t frame_diff(input pix_t nxt, input pix_t prv);
    diff_t a;
    diff_t b;
    a = diff_t'({1'b0, nxt});
    b = diff_t'({1'b0, prv});
    return a - b;
  endfunction

  // magnitude of the 1-2-1 weighted lateral sum
  function automatic mot_t lateral_motion(input diff_t l, input diff_t c, input diff_t r);
    logic signed [SUM_W-1:0] sl;
    logic signed [SUM_W-1:0] sc;
    logic signed [SUM_W-1:0] sr;
    logic signed [SUM_W-1:0] s;
    logic signed [SUM_W-1:0] mag;
    sl  = {{(SUM_W-DIFF_W){l[DIFF_W-1]}}, l};
    sc  = {{(SUM_W-DIFF_W){c[DIFF_W-1]}}, c};
    sr  = {{(SUM_W-DIFF_W){r[DIFF_W-1]}}, r};
    s   = sl + (sc <<< 1) + sr;
    mag = s[SUM_W-1] ? -s : s;
    return mag[MOT_W-1:0];
  endfunction

  // signed test: current minus background strictly above the threshold
  function automatic logic brighter_than(input pix_t cur, input pix_t bg, input pix_t thr);
    diff_t gap;
    diff_t lim;
    gap = diff_t'({1'b0, cur}) - diff_t'({1'b0, bg});
    lim = diff_t'({1'b0, thr});
    return gap > lim;
  endfunction

endpackage

// File: rtl/mdet_window.sv
module mdet_window
  import mdet_pkg::*;
#(
  parameter int FRAME_W = 1280,
  parameter int NB_DIST = 10,
  parameter int PAY_W   = 35
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         shift_en,
  input  logic                         in_valid,
  input  diff_t                        in_d,
  input  logic [$clog2(FRAME_W)-1:0]   in_col,
  input  logic [PAY_W-1:0]             in_pay,
  output logic                         ctr_valid,
  output logic [PAY_W-1:0]             ctr_pay,
  output diff_t                        ctr_d,
  output diff_t                        left_d,
  output diff_t                        right_d
);

  localparam int COL_W = $clog2(FRAME_W);
  localparam int CTR   = NB_DIST;
  localparam int LFT   = 2 * NB_DIST;

  logic             vld_q [0:LFT];
  diff_t            d_q   [0:LFT];
  logic [COL_W-1:0] col_q [0:CTR];
  logic [PAY_W-1:0] pay_q [0:CTR];

  // tap 0 is the newest sample; payload travels only as far as the centre
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k <= LFT; k++) begin
        vld_q[k] <= 1'b0;
        d_q[k]   <= '0;
      end
      for (int k = 0; k <= CTR; k++) begin
        col_q[k] <= '0;
        pay_q[k] <= '0;
      end
    end else if (shift_en) begin
      vld_q[0] <= in_valid;
      d_q[0]   <= in_d;
      col_q[0] <= in_col;
      pay_q[0] <= in_pay;
      for (int k = 1; k <= LFT; k++) begin
        vld_q[k] <= vld_q[k-1];
        d_q[k]   <= d_q[k-1];
      end
      for (int k = 1; k <= CTR; k++) begin
        col_q[k] <= col_q[k-1];
        pay_q[k] <= pay_q[k-1];
      end
    end
  end

  logic [COL_W:0] right_col;
  logic           left_in_row;
  logic           right_in_row;

  assign right_col    = {1'b0, col_q[CTR]} + (COL_W+1)'(NB_DIST);
  assign left_in_row  = col_q[CTR] >= COL_W'(NB_DIST);
  assign right_in_row = right_col < (COL_W+1)'(FRAME_W);

  assign ctr_valid = vld_q[CTR];
  assign ctr_pay   = pay_q[CTR];
  assign ctr_d     = d_q[CTR];
  assign left_d    = (left_in_row  && vld_q[LFT]) ? d_q[LFT] : d_q[CTR];
  assign right_d   = (right_in_row && vld_q[0])   ? d_q[0]   : d_q[CTR];

  // an in-row right neighbour must already be in the window when the centre is decided
  AST_RIGHT_PRESENT: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en && ctr_valid && right_in_row |-> vld_q[0]); // R2

endmodule

// File: rtl/mdet_decide.sv
module mdet_decide
  import mdet_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             chk_en,
  input  logic             road,
  input  pix_t             bg_px,
  input  pix_t             cur_px,
  input  logic [CNT_W-1:0] cnt_in,
  input  diff_t            left_d,
  input  diff_t            ctr_d,
  input  diff_t            right_d,
  input  mot_t             mot_thr,
  input  pix_t             bg_thr,
  input  logic [CNT_W-1:0] still_n,
  output logic             moving,
  output pix_t             out_px,
  output pix_t             new_bg,
  output logic [CNT_W-1:0] new_cnt
);

  mot_t motion_raw;
  mot_t motion;
  logic is_still;
  logic aged;
  logic take_bg;
  logic cnt_full;
  logic gap_hit;

  always_comb begin
    motion_raw = lateral_motion(left_d, ctr_d, right_d);
    motion     = road ? motion_raw : '0;
    is_still   = motion < mot_thr;
    aged       = cnt_in >= still_n;
    take_bg    = is_still && aged;
    cnt_full   = &cnt_in;
    gap_hit    = brighter_than(cur_px, bg_px, bg_thr);
    moving     = gap_hit && (motion > mot_thr);
    out_px     = moving  ? cur_px : '0;
    new_bg     = take_bg ? cur_px : bg_px;
    if (take_bg)       new_cnt = '0;
    else if (cnt_full) new_cnt = cnt_in;
    else               new_cnt = cnt_in + CNT_W'(1);
  end

  AST_CNT_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    chk_en && !take_bg |-> new_cnt >= cnt_in); // R5

  AST_OFFROAD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    chk_en && !road |-> !moving && out_px == '0); // R3

endmodule

// File: rtl/mdet_area_acc.sv
module mdet_area_acc #(
  parameter int AREA_W = 8,
  parameter int ACC_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              consume,
  input  logic              sof,
  input  logic              last,
  input  logic              moving,
  input  logic [AREA_W-1:0] area,
  output logic [ACC_W-1:0]  total,
  output logic              done
);

  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] add_v;
  logic [ACC_W-1:0] base_v;
  logic [ACC_W:0]   sum_v;
  logic [ACC_W-1:0] acc_n;

  always_comb begin
    add_v  = moving ? {{(ACC_W-AREA_W){1'b0}}, area} : '0;
    base_v = sof ? '0 : acc_q;
    sum_v  = {1'b0, base_v} + {1'b0, add_v};
    acc_n  = sum_v[ACC_W] ? {ACC_W{1'b1}} : sum_v[ACC_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      total <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (consume) begin
        acc_q <= acc_n;
        if (last) begin
          total <= acc_n;
          done  <= 1'b1;
        end
      end
    end
  end

  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(consume && last)); // R7

  AST_ACC_NO_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    consume && !sof |=> acc_q >= $past(acc_q)); // R7

endmodule

// File: rtl/mdet_top.sv
module mdet_top
  import mdet_pkg::*;
#(
  parameter int FRAME_W = 1280,
  parameter int NB_DIST = 10,
  parameter int CNT_W   = 8,
  parameter int AREA_W  = 8,
  parameter int ACC_W   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic              s_sof,
  input  logic              s_last,
  input  logic [7:0]        s_bg,
  input  logic [7:0]        s_prev,
  input  logic [7:0]        s_cur,
  input  logic [7:0]        s_next,
  input  logic              s_road,
  input  logic [AREA_W-1:0] s_area,
  input  logic [CNT_W-1:0]  s_cnt,
  input  logic [9:0]        cfg_mot_thr,
  input  logic [7:0]        cfg_bg_thr,
  input  logic [CNT_W-1:0]  cfg_still_n,
  output logic              m_valid,
  input  logic              m_ready,
  output logic [7:0]        m_pix,
  output logic [7:0]        m_bg,
  output logic [CNT_W-1:0]  m_cnt,
  output logic [ACC_W-1:0]  area_total,
  output logic              area_done
);

  localparam int COL_W   = $clog2(FRAME_W);
  localparam int PAY_W   = 3 + 2 * PIX_W + AREA_W + CNT_W;
  localparam int FLUSH_N = NB_DIST + 1;
  localparam int FL_W    = $clog2(FLUSH_N + 1);

  // handshake and drain control, brought out as named events
  logic            stall;
  logic            adv;
  logic            flushing;
  logic            s_fire;
  logic            shift_en;
  logic            consume;
  logic [FL_W-1:0] flush_q;

  assign stall    = m_valid && !m_ready;
  assign adv      = !stall;
  assign flushing = flush_q != '0;
  assign s_ready  = adv && !flushing;
  assign s_fire   = s_valid && s_ready;
  assign shift_en = s_fire || (adv && flushing);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     flush_q <= '0;
    else if (s_fire && s_last)      flush_q <= FL_W'(FLUSH_N);
    else if (adv && flushing)       flush_q <= flush_q - FL_W'(1);
  end

  // column of the incoming pixel
  logic [COL_W-1:0] col_q;
  logic [COL_W-1:0] in_col;

  assign in_col = s_sof ? '0 : col_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      col_q <= '0;
    else if (s_fire) col_q <= (in_col == COL_W'(FRAME_W - 1)) ? '0 : in_col + COL_W'(1);
  end

  // neighbour window
  diff_t            in_d;
  logic [PAY_W-1:0] in_pay;
  logic             ctr_valid;
  logic [PAY_W-1:0] ctr_pay;
  diff_t            ctr_d;
  diff_t            left_d;
  diff_t            right_d;

  assign in_d   = frame_diff(s_next, s_prev);
  assign in_pay = {s_sof, s_last, s_road, s_bg, s_cur, s_area, s_cnt};

  mdet_window #(
    .FRAME_W (FRAME_W),
    .NB_DIST (NB_DIST),
    .PAY_W   (PAY_W)
  ) u_window (
    .clk       (clk),
    .rst_n     (rst_n),
    .shift_en  (shift_en),
    .in_valid  (s_fire),
    .in_d      (in_d),
    .in_col    (in_col),
    .in_pay    (in_pay),
    .ctr_valid (ctr_valid),
    .ctr_pay   (ctr_pay),
    .ctr_d     (ctr_d),
    .left_d    (left_d),
    .right_d   (right_d)
  );

  logic              c_sof;
  logic              c_last;
  logic              c_road;
  pix_t              c_bg;
  pix_t              c_cur;
  logic [AREA_W-1:0] c_area;
  logic [CNT_W-1:0]  c_cnt;

  assign {c_sof, c_last, c_road, c_bg, c_cur, c_area, c_cnt} = ctr_pay;
  assign consume = shift_en && ctr_valid;

  // per-pixel decision
  logic             ev_moving;
  pix_t             d_pix;
  pix_t             d_bg;
  logic [CNT_W-1:0] d_cnt;

  mdet_decide #(
    .CNT_W (CNT_W)
  ) u_decide (
    .clk     (clk),
    .rst_n   (rst_n),
    .chk_en  (consume),
    .road    (c_road),
    .bg_px   (c_bg),
    .cur_px  (c_cur),
    .cnt_in  (c_cnt),
    .left_d  (left_d),
    .ctr_d   (ctr_d),
    .right_d (right_d),
    .mot_thr (cfg_mot_thr),
    .bg_thr  (cfg_bg_thr),
    .still_n (cfg_still_n),
    .moving  (ev_moving),
    .out_px  (d_pix),
    .new_bg  (d_bg),
    .new_cnt (d_cnt)
  );

  // output register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_valid <= 1'b0;
      m_pix   <= '0;
      m_bg    <= '0;
      m_cnt   <= '0;
    end else if (shift_en) begin
      m_valid <= ctr_valid;
      m_pix   <= d_pix;
      m_bg    <= d_bg;
      m_cnt   <= d_cnt;
    end else if (m_ready) begin
      m_valid <= 1'b0;
    end
  end

  mdet_area_acc #(
    .AREA_W (AREA_W),
    .ACC_W  (ACC_W)
  ) u_area (
    .clk     (clk),
    .rst_n   (rst_n),
    .consume (consume),
    .sof     (c_sof),
    .last    (c_last),
    .moving  (ev_moving),
    .area    (c_area),
    .total   (area_total),
    .done    (area_done)
  );

  AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && !m_ready |=> m_valid && $stable(m_pix) && $stable(m_bg) && $stable(m_cnt)); // R8

  AST_NO_ACCEPT_IN_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    flushing |-> !s_ready); // R9

  AST_FLUSH_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    s_fire && s_last |=> !s_ready); // R9

endmodule

// File: tb/tb_mdet_top.sv
module tb_mdet_top;

  localparam int FW    = 24;
  localparam int NB    = 10;
  localparam int FH    = 3;
  localparam int NPIX  = FW * FH;
  localparam int NFR   = 5;
  localparam int TOT   = NFR * NPIX;
  localparam int CW    = 8;
  localparam int AW    = 8;
  localparam int ACW   = 32;
  localparam int LIMIT = 60000;

  // frame recipes: seed, motion thr, bg thr, still count, stall flag, mode (1 = all off road)
  localparam logic [47:0] TBL [NFR] = '{
    {8'd1, 16'd200, 8'd20, 8'd100, 4'd0, 4'd0},
    {8'd2, 16'd80,  8'd0,  8'd3,   4'd1, 4'd0},
    {8'd3, 16'd400, 8'd60, 8'd200, 4'd1, 4'd0},
    {8'd4, 16'd150, 8'd10, 8'd50,  4'd0, 4'd1},
    {8'd5, 16'd0,   8'd255,8'd0,   4'd0, 4'd0}
  };

  logic          clk;
  logic          rst_n;
  logic          s_valid;
  logic          s_ready;
  logic          s_sof;
  logic          s_last;
  logic [7:0]    s_bg, s_prev, s_cur, s_next;
  logic          s_road;
  logic [AW-1:0] s_area;
  logic [CW-1:0] s_cnt;
  logic [9:0]    cfg_mot_thr;
  logic [7:0]    cfg_bg_thr;
  logic [CW-1:0] cfg_still_n;
  logic          m_valid;
  logic          m_ready;
  logic [7:0]    m_pix, m_bg;
  logic [CW-1:0] m_cnt;
  logic [ACW-1:0] area_total;
  logic          area_done;

  mdet_top #(
    .FRAME_W (FW),
    .NB_DIST (NB),
    .CNT_W   (CW),
    .AREA_W  (AW),
    .ACC_W   (ACW)
  ) dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .s_valid     (s_valid),
    .s_ready     (s_ready),
    .s_sof       (s_sof),
    .s_last      (s_last),
    .s_bg        (s_bg),
    .s_prev      (s_prev),
    .s_cur       (s_cur),
    .s_next      (s_next),
    .s_road      (s_road),
    .s_area      (s_area),
    .s_cnt       (s_cnt),
    .cfg_mot_thr (cfg_mot_thr),
    .cfg_bg_thr  (cfg_bg_thr),
    .cfg_still_n (cfg_still_n),
    .m_valid     (m_valid),
    .m_ready     (m_ready),
    .m_pix       (m_pix),
    .m_bg        (m_bg),
    .m_cnt       (m_cnt),
    .area_total  (area_total),
    .area_done   (area_done)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  int out_n  = 0;
  int done_n = 0;
  int cyc    = 0;

  int st_bg [TOT];
  int st_pv [TOT];
  int st_cu [TOT];
  int st_nx [TOT];
  int st_rd [TOT];
  int st_ar [TOT];
  int st_ct [TOT];
  int e_pix [TOT];
  int e_bg  [TOT];
  int e_cnt [TOT];
  longint e_area [NFR];

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  function automatic int unsigned hsh(input int unsigned k);
    int unsigned x;
    x = k * 32'h9E3779B1;
    x = x ^ (x >> 15);
    x = x * 32'h85EBCA6B;
    x = x ^ (x >> 13);
    return x;
  endfunction

  // stimulus and expected values for one frame, from the requirements
  task automatic build_frame(input int f);
    int seed, mthr, bthr, nst, mode, base;
    int dd [NPIX];
    longint area;
    seed = int'(TBL[f][47:40]);
    mthr = int'(TBL[f][33:24]);
    bthr = int'(TBL[f][23:16]);
    nst  = int'(TBL[f][15:8]);
    mode = int'(TBL[f][3:0]);
    base = f * NPIX;
    area = 0;
    for (int i = 0; i < NPIX; i++) begin
      int unsigned h6;
      st_bg[base+i] = int'(hsh(seed*100000 + i*8 + 0) & 8'hFF);
      st_pv[base+i] = int'(hsh(seed*100000 + i*8 + 1) & 8'hFF);
      st_cu[base+i] = int'(hsh(seed*100000 + i*8 + 2) & 8'hFF);
      st_nx[base+i] = int'(hsh(seed*100000 + i*8 + 3) & 8'hFF);
      st_rd[base+i] = (mode == 1) ? 0 : ((hsh(seed*100000 + i*8 + 4) & 3) != 0 ? 1 : 0);
      st_ar[base+i] = int'(hsh(seed*100000 + i*8 + 5) & 8'hFF);
      h6 = hsh(seed*100000 + i*8 + 6);
      if (h6 % 5 == 0)      st_ct[base+i] = 255;
      else if (h6 % 5 == 1) st_ct[base+i] = nst;
      else                  st_ct[base+i] = int'(h6 & 8'hFF);
      dd[i] = st_nx[base+i] - st_pv[base+i];
    end
    for (int i = 0; i < NPIX; i++) begin
      int col, dl, dr, s, mot, bg, cu, ct;
      bit take, mov;
      col = i % FW;
      dl  = (col >= NB)     ? dd[i-NB] : dd[i];
      dr  = (col + NB < FW) ? dd[i+NB] : dd[i];
      s   = dl + 2*dd[i] + dr;
      mot = (s < 0) ? -s : s;
      if (st_rd[base+i] == 0) mot = 0;
      bg = st_bg[base+i];
      cu = st_cu[base+i];
      ct = st_ct[base+i];
      take = (mot < mthr) && (ct >= nst);
      mov  = ((cu - bg) > bthr) && (mot > mthr);
      e_bg[base+i]  = take ? cu : bg;
      e_cnt[base+i] = take ? 0 : ((ct == 255) ? 255 : ct + 1);
      e_pix[base+i] = mov ? cu : 0;
      if (mov) area += st_ar[base+i];
    end
    e_area[f] = area;
  endtask

  // downstream readiness, changed just after each rising edge
  logic [15:0] lfsr = 16'hACE1;
  logic        stall_mode = 1'b0;
  initial m_ready = 1'b1;
  always @(posedge clk) begin
    #1;
    lfsr    <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    m_ready <= stall_mode ? (lfsr[0] | lfsr[5]) : 1'b1;
  end

  // output monitor
  bit         hold_pend = 1'b0;
  logic [7:0] h_pix, h_bg;
  logic [CW-1:0] h_cnt;
  always @(negedge clk) begin
    if (rst_n) begin
      if (hold_pend)
        chk(m_valid && m_pix == h_pix && m_bg == h_bg && m_cnt == h_cnt,
            "R8", "output held while stalled", longint'({m_valid, m_pix}), longint'({1'b1, h_pix}));
      hold_pend = m_valid && !m_ready;
      h_pix = m_pix;
      h_bg  = m_bg;
      h_cnt = m_cnt;
      if (m_valid && m_ready) begin
        if (out_n < TOT) begin
          chk(int'(m_pix) == e_pix[out_n], "R2/R3/R6", $sformatf("masked pixel %0d", out_n), m_pix, e_pix[out_n]);
          chk(int'(m_bg)  == e_bg[out_n],  "R4", $sformatf("background %0d", out_n), m_bg, e_bg[out_n]);
          chk(int'(m_cnt) == e_cnt[out_n], "R5", $sformatf("counter %0d", out_n), m_cnt, e_cnt[out_n]);
        end else begin
          chk(1'b0, "R8", "extra output", out_n, TOT);
        end
        out_n++;
      end
      if (area_done) begin
        if (done_n < NFR)
          chk(longint'(area_total) == e_area[done_n], "R7", $sformatf("frame %0d area", done_n), area_total, e_area[done_n]);
        done_n++;
      end
    end
  end

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc == LIMIT) begin
      fails++;
      $display("FAIL R8 watchdog: actual %0d cycles expected < %0d", cyc, LIMIT);
      summary();
      $finish;
    end
  end

  task automatic push(input int g, input bit sof, input bit last);
    s_valid = 1'b1;
    s_sof   = sof;
    s_last  = last;
    s_bg    = st_bg[g][7:0];
    s_prev  = st_pv[g][7:0];
    s_cur   = st_cu[g][7:0];
    s_next  = st_nx[g][7:0];
    s_road  = st_rd[g][0];
    s_area  = st_ar[g][AW-1:0];
    s_cnt   = st_ct[g][CW-1:0];
    while (!s_ready) @(negedge clk);
    @(negedge clk);
    s_valid = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0;
    s_valid = 1'b0; s_sof = 1'b0; s_last = 1'b0;
    s_bg = '0; s_prev = '0; s_cur = '0; s_next = '0;
    s_road = 1'b0; s_area = '0; s_cnt = '0;
    cfg_mot_thr = '0; cfg_bg_thr = '0; cfg_still_n = '0;
    repeat (3) @(negedge clk);
    chk(m_valid == 1'b0,   "R1", "m_valid in reset", m_valid, 0);
    chk(area_done == 1'b0, "R1", "area_done in reset", area_done, 0);
    chk(area_total == '0,  "R1", "area_total in reset", area_total, 0);
    chk(s_ready == 1'b1,   "R1", "s_ready in reset", s_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(m_valid == 1'b0 && s_ready == 1'b1, "R1", "state after reset", {m_valid, s_ready}, 1);

    // one loop walks the recipe table
    for (int f = 0; f < NFR; f++) begin
      build_frame(f);
      cfg_mot_thr = TBL[f][33:24];
      cfg_bg_thr  = TBL[f][23:16];
      cfg_still_n = TBL[f][15:8];
      stall_mode  = TBL[f][4];
      @(negedge clk);
      @(negedge clk);
      for (int i = 0; i < NPIX; i++)
        push(f*NPIX + i, i == 0, i == NPIX-1);
      if (TBL[f][4] == 1'b0) begin
        // directed drain check: ready stays low for NB+1 cycles (R9)
        for (int k = 0; k <= NB; k++) begin
          chk(s_ready == 1'b0, "R9", $sformatf("ready low during drain, step %0d", k), s_ready, 0);
          @(negedge clk);
        end
        chk(s_ready == 1'b1, "R9", "ready back after drain", s_ready, 1);
      end else begin
        while (!s_ready) @(negedge clk);
      end
    end

    stall_mode = 1'b0;
    for (int w = 0; w < 200 && (out_n < TOT || done_n < NFR); w++) @(negedge clk);
    chk(out_n == TOT,  "R8", "outputs produced", out_n, TOT);
    chk(done_n == NFR, "R7", "frame totals released", done_n, NFR);
    repeat (3) @(negedge clk);
    chk(m_valid == 1'b0 && area_done == 1'b0, "R8", "quiet once drained", {m_valid, area_done}, 0);
    summary();
    $finish;
  end

endmodule